// File: doc/BRIEF.md
# Split Binary Up-Counter with Test Gating

This block is a wide binary up-counter assembled from two equal halves. In functional operation the halves form one counter: the low half steps on every enabled clock, and the high half steps when the low half rolls over. Exhaustive testing of a 16-bit counter would need 65536 clocks. This block adds gating between the halves so that a tester can separate them. Each half can then be exercised on its own, which takes 2 × 256 = 512 clocks, or both can run in parallel in 256 clocks.

While `test_mode` is high, two inhibit controls cut the link between the halves. One inhibit swaps the low half's rollover for a tester-driven data bit. The other swaps the functional enable of the high half for a tester-driven tick. The tester tick is a synchronous enable sampled on the one system clock, so the block has a single clock domain. The low half's rollover is always driven onto an observation output. Reset is asserted asynchronously and released through a two-stage synchronizer, so the counter leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `split_counter`

## Requirements
- R1: While reset is applied, `count` is 0x0000. Asserting `rst_n` low clears the counter at once, without waiting for a clock edge.
- R2: The low half (`count[7:0]`) rises by one on every clock edge at which `en` is 1, and rolls from 0xFF to 0x00. When `en` is 0 it keeps its value.
- R3: When `test_mode` is 0, `count` behaves as a plain 16-bit up-counter gated by `en`, including the step from 0xFFFF to 0x0000. The inputs `data_inh`, `clk_inh`, `tst_clk` and `tst_data` have no effect in this mode.
- R4: `carry_obs` is 1 exactly when the low half is 0xFF and `en` is 1. These are the cycles in which the low half rolls over on the next edge.
- R5: With `test_mode`=1 and `data_inh`=1, the high half (`count[15:8]`) takes `tst_data` in place of the low-half rollover. With `tst_data`=0, the high half holds even when the low half wraps.
- R6: With `test_mode`=1 and `clk_inh`=1, the high half takes `tst_clk` in place of `en` as its tick. It can then step while `en`=0, and holds when `tst_clk`=0.
- R7: With `test_mode`=1, `data_inh`=1, `tst_data`=1, `clk_inh`=0 and `en`=1, both halves step on every edge. After 256 edges the counter is back at its starting value.
- R8: In test mode the high half rolls from 0xFF to 0x00 without changing the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Count enable (functional tick) |
| test_mode | input | 1 | Enables the test gating between halves |
| data_inh | input | 1 | Replace low-half rollover with `tst_data` |
| clk_inh | input | 1 | Replace high-half tick `en` with `tst_clk` |
| tst_clk | input | 1 | Tester tick for the high half (synchronous enable) |
| tst_data | input | 1 | Tester carry value for the high half |
| count | output | 16 | Counter value, high half in bits 15:8 |
| carry_obs | output | 1 | Observation point: low-half rollover |

## Verification
The assertions check on every cycle the per-edge relationships:
- how the low half steps and holds;
- how the high half holds under each inhibit;
- the parallel step;
- the 0xFFFF wrap;
- that the observation output is followed by a low half of zero.

Only the bench scenarios can show the longer behaviour:
- the full 256-cycle return in parallel mode;
- the low half wrapping while the high half is held;
- the inhibit inputs being ignored outside test mode;
- the asynchronous clear in the middle of a count.

// File: rtl/split_counter_pkg.sv
package split_counter_pkg;

  localparam int unsigned HALF_W_DEF = 8;

  typedef struct packed {
    logic mode;
    logic data_inh;
    logic clk_inh;
    logic tick;
    logic data;
  } tctl_t;

endpackage

// File: rtl/split_rst_sync.sv
module split_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/split_half_cnt.sv
module split_half_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         at_max
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (step) begin
      val_d = val_q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign value  = val_q;
  assign at_max = &val_q;

endmodule

// File: rtl/split_link_gate.sv
module split_link_gate
  import split_counter_pkg::*;
(
  input  logic  en,
  input  logic  lo_at_max,
  input  tctl_t tctl,
  output logic  lo_step,
  output logic  up_step,
  output logic  lo_carry
);

  logic carry_sel;
  logic up_tick;

  always_comb begin
    lo_step  = en;
    lo_carry = lo_at_max & en;
    if (tctl.mode) begin
      carry_sel = tctl.data_inh ? tctl.data : lo_carry;
      up_tick   = tctl.clk_inh  ? tctl.tick : en;
      up_step   = carry_sel & up_tick;
    end else begin
      carry_sel = lo_carry;
      up_tick   = en;
      up_step   = lo_carry;
    end
  end

endmodule

// File: rtl/split_counter.sv
module split_counter
  import split_counter_pkg::*;
#(
  parameter int unsigned HALF_W = HALF_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                test_mode,
  input  logic                data_inh,
  input  logic                clk_inh,
  input  logic                tst_clk,
  input  logic                tst_data,
  output logic [2*HALF_W-1:0] count,
  output logic                carry_obs
);

  localparam int unsigned NHALF = 2;

  logic        rst_sync_n;
  logic [NHALF-1:0] half_step;
  logic [NHALF-1:0] half_max;
  logic [HALF_W-1:0] half_val [NHALF];
  tctl_t       tctl;

  split_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    tctl.mode     = test_mode;
    tctl.data_inh = data_inh;
    tctl.clk_inh  = clk_inh;
    tctl.tick     = tst_clk;
    tctl.data     = tst_data;
  end

  split_link_gate u_gate (
    .en       (en),
    .lo_at_max(half_max[0]),
    .tctl     (tctl),
    .lo_step  (half_step[0]),
    .up_step  (half_step[1]),
    .lo_carry (carry_obs)
  );

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    split_half_cnt #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .step  (half_step[g]),
      .value (half_val[g]),
      .at_max(half_max[g])
    );
    assign count[g*HALF_W +: HALF_W] = half_val[g];
  end

endmodule

// File: rtl/split_counter_chk.sv
module split_counter_chk #(
  parameter int unsigned HALF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                test_mode,
  input logic                data_inh,
  input logic                clk_inh,
  input logic                tst_clk,
  input logic                tst_data,
  input logic [2*HALF_W-1:0] count,
  input logic                carry_obs
);

  logic [HALF_W-1:0] lo, up, lo_inc, up_inc;
  assign lo     = count[HALF_W-1:0];
  assign up     = count[2*HALF_W-1:HALF_W];
  assign lo_inc = lo + {{(HALF_W-1){1'b0}}, 1'b1};
  assign up_inc = up + {{(HALF_W-1){1'b0}}, 1'b1};

  a_r2_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> lo == $past(lo_inc));

  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lo));

  a_r3_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && en && count == '1) |=> count == '0);

  a_r3_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !(en && lo == '1)) |=> $stable(up));

  a_r4_obs_then_zero: assert property (@(posedge clk) disable iff (!rst_n)
    carry_obs |=> lo == '0);

  a_r4_obs_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !carry_obs);

  a_r5_data_block: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && data_inh && !tst_data) |=> $stable(up));

  a_r6_tick_block: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && clk_inh && !tst_clk) |=> $stable(up));

  a_r7_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && data_inh && tst_data && !clk_inh && en) |=> up == $past(up_inc));

endmodule

bind split_counter split_counter_chk #(.HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en       (en),
  .test_mode(test_mode),
  .data_inh (data_inh),
  .clk_inh  (clk_inh),
  .tst_clk  (tst_clk),
  .tst_data (tst_data),
  .count    (count),
  .carry_obs(carry_obs)
);

// File: tb/split_counter_tb_top.sv
module split_counter_tb_top;

  logic        clk;
  logic        rst_n;
  logic        en, test_mode, data_inh, clk_inh, tst_clk, tst_data;
  logic [15:0] count;
  logic        carry_obs;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  split_counter #(.HALF_W(8)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .test_mode(test_mode),
    .data_inh (data_inh),
    .clk_inh  (clk_inh),
    .tst_clk  (tst_clk),
    .tst_data (tst_data),
    .count    (count),
    .carry_obs(carry_obs)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: en, test_mode, data_inh, clk_inh, tst_clk, tst_data, expected count
  localparam logic [21:0] VEC [10] = '{
    {6'b000000, 16'h0000},  // R2 hold with en low
    {6'b100000, 16'h0001},  // R2 step
    {6'b101001, 16'h0002},  // R3 inhibits ignored outside test mode
    {6'b111001, 16'h0103},  // R7 parallel step
    {6'b011001, 16'h0103},  // R6 tick is en, en low -> hold
    {6'b011111, 16'h0203},  // R6 tester tick steps high half
    {6'b111101, 16'h0204},  // R6 tester tick low -> high half holds
    {6'b111000, 16'h0205},  // R5 tester data 0 blocks
    {6'b100100, 16'h0206},  // R3 clock inhibit ignored outside test mode
    {6'b000000, 16'h0206}   // R2 hold
  };

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count=%h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: carry_obs=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c);
    {en, test_mode, data_inh, clk_inh, tst_clk, tst_data} = c;
  endtask

  task automatic run(input logic [5:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(c);
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(6'b0);
    repeat (3) @(posedge clk);
    #1;
    chk16("R1 in reset", count, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk16("R1 after release", count, 16'h0000);

    for (int v = 0; v < 10; v++) begin
      run(VEC[v][21:16], 1);
      chk16($sformatf("vector %0d", v), count, VEC[v][15:0]);
    end

    // R4: approach low-half rollover in normal mode
    run(6'b100000, 249);
    chk16("R2 reach 02FF", count, 16'h02FF);
    chk1("R4 obs high at FF with en", carry_obs, 1'b1);
    @(negedge clk);
    drive(6'b000000);
    #1;
    chk1("R4 obs low with en low", carry_obs, 1'b0);
    run(6'b100000, 1);
    chk16("R3 carry into high half", count, 16'h0300);
    chk1("R4 obs low after wrap", carry_obs, 1'b0);

    // R5: tester data 0, low half wraps with high held
    run(6'b111000, 255);
    chk16("R5 low at FF", count, 16'h03FF);
    run(6'b111000, 1);
    chk16("R5 high held over low wrap", count, 16'h0300);

    // R7/R8: parallel run
    run(6'b111001, 253);
    chk16("R8 high half wraps alone", count, 16'h00FD);
    run(6'b111001, 3);
    chk16("R7 256 edges return", count, 16'h0300);

    // R3: full wrap
    run(6'b111001, 252);
    chk16("R7 setup FFFC", count, 16'hFFFC);
    run(6'b100000, 3);
    chk16("R3 reach FFFF", count, 16'hFFFF);
    chk1("R4 obs at FFFF", carry_obs, 1'b1);
    run(6'b100000, 1);
    chk16("R3 wrap to 0000", count, 16'h0000);
    run(6'b000000, 1);
    chk16("R2 hold at 0000", count, 16'h0000);

    // R1: asynchronous clear mid-count
    run(6'b100000, 2);
    chk16("R2 count to 0002", count, 16'h0002);
    #1;
    rst_n = 1'b0;
    #1;
    chk16("R1 async clear", count, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule